// File: doc/BRIEF.md
# Per-Pin Test Waveform Formatter

This block shapes one tester pin. A stream of pattern bits arrives at one bit per test period. Each period is cut into `N` ticks of a fast clock, and the block turns each bit into a drive waveform on that tick grid. There are two formats. In the non-return format the pin moves to the new bit once, at a programmable delay tick. In the return format a bit of 1 becomes one pulse that starts at the delay tick and lasts a programmable number of ticks. A polarity setting selects a positive pulse or a negative pulse. The same block samples the device response at a programmable strobe tick. When comparison is enabled, it flags a mismatch against the expected bit once per period.

Settings and bits are taken in at each period boundary. Changes made in the middle of a period therefore only shape the following period. If a setting set cannot fit inside a period, it is rejected. For that period the pin holds its level, no comparison is made, and an error flag is shown.

A small state machine sequences each period through named states. `PRE` means before the delay tick. `ACT` means the new level or the pulse is being driven. `POST` means an RZ pulse has ended and the pin is back at its base level. `REJ` means the period was rejected. At every period wrap the machine enters `REJ` for a rejected setting. Otherwise it enters `PRE` when the delay is nonzero, `POST` for an RZ setting with zero width, and `ACT` in all other cases. Within a period the machine moves `PRE -> ACT` at the delay tick, or `PRE -> POST` when the RZ width is zero. It moves `ACT -> POST` at tick delay+width in RZ format. `POST` and `REJ` hold until the next wrap.

Top module: `pin_wave_formatter`

## Requirements
- R1: A period lasts exactly `N` clock cycles (ticks 0 to N-1). `period_start` is high only during tick 0, and the first cycle after reset is tick 0.
- R2: Pattern bit, expected bit, compare enable and all settings are captured on the clock edge that ends tick N-1. They govern the whole following period, so an input change during a period does not alter that period's waveform.
- R3: In NRZ format (`rz_mode`=0), `drive` keeps the level it had at the end of the previous period until tick `delay_ticks`. From that tick to the end of the period it equals the pattern bit, so it changes at most once per period.
- R4: In RZ format with `neg_pulse`=0, a pattern bit of 1 drives 1 for ticks delay to delay+width-1 and drives 0 at every other tick of the period.
- R5: In RZ format with `neg_pulse`=1, the base level is 1. A pattern bit of 1 drives 0 for ticks delay to delay+width-1 and drives 1 at every other tick.
- R6: In RZ format a pattern bit of 0, or a width of 0, leaves `drive` at the base level for the whole period.
- R7: The response is sampled only at tick `strobe_tick`. Values of `dut_resp` at other ticks do not affect the result.
- R8: A setting is rejected when delay >= N, or strobe >= N, or (in RZ format) delay+width > N. For that period `cfg_err` is 1, `drive` holds its previous level for all N ticks, and `fail` ends up 0. In every other period `cfg_err` is 0.
- R9: `fail` is updated at the end of each period and holds for the next full period. It is 1 only if compare was enabled, the setting was accepted, and the sampled response differed from the expected bit.
- R10: Under reset `drive`, `fail` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_bit | input | 1 | Pattern bit for the next period |
| exp_bit | input | 1 | Expected response for the next period |
| cmp_en | input | 1 | Enable response comparison |
| rz_mode | input | 1 | 0 = NRZ, 1 = RZ |
| neg_pulse | input | 1 | RZ polarity: 0 = base 0 / positive pulse, 1 = base 1 / negative pulse |
| delay_ticks | input | $clog2(N+1) | Tick of the NRZ edge or RZ leading edge |
| width_ticks | input | $clog2(N+1) | RZ pulse length in ticks |
| strobe_tick | input | $clog2(N+1) | Tick at which the response is sampled |
| dut_resp | input | 1 | Device response |
| drive | output | 1 | Formatted pin waveform |
| period_start | output | 1 | High during tick 0 of each period |
| fail | output | 1 | Mismatch result of the previous period |
| cfg_err | output | 1 | Current period's setting was rejected |

## Verification
The in-line assertions check these properties on every cycle:
- the counter wraps to tick 0 after the last tick;
- an NRZ period moves `drive` only at its delay tick;
- an RZ period sits at its base level before the delay;
- a rejected period keeps `drive` still;
- `fail` never rises without an accepted, compare-enabled period behind it.

Some behaviour can only be shown by the bench scenarios:
- the exact pulse span for both polarities;
- the boundary where delay+width equals N;
- that a mid-period input change is deferred to the next period;
- that the response counts only at the strobe tick.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    typedef enum logic [1:0] {
        ST_PRE  = 2'd0,
        ST_ACT  = 2'd1,
        ST_POST = 2'd2,
        ST_REJ  = 2'd3
    } wave_st_e;
endpackage

// File: rtl/fmt_tick_ctr.sv
module fmt_tick_ctr #(
    parameter int N  = 8,
    parameter int TW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tick,
    output logic [TW-1:0] tick_nxt,
    output logic          last
);
    localparam logic [TW-1:0] LAST_TK = TW'(N - 1);

    assign last     = (tick == LAST_TK);
    assign tick_nxt = last ? '0 : tick + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick <= '0;
        else        tick <= tick_nxt;
    end

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (tick == '0));
endmodule

// File: rtl/fmt_shaper.sv
module fmt_shaper
    import fmt_pkg::*;
#(
    parameter int N  = 8,
    parameter int TW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          last,
    input  logic [TW-1:0] tick_nxt,
    input  logic          nx_rz,
    input  logic [TW-1:0] nx_dly,
    input  logic [TW-1:0] nx_wid,
    input  logic          nx_bad,
    input  logic          cu_rz,
    input  logic          cu_neg,
    input  logic          cu_pat,
    input  logic [TW-1:0] cu_dly,
    input  logic [TW-1:0] cu_wid,
    output logic          drive
);
    wave_st_e    st_q, st_d;
    logic        hold_q;
    logic [TW:0] end_tk;

    assign end_tk = {1'b0, cu_dly} + {1'b0, cu_wid};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_ACT;
            hold_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            if (last) hold_q <= drive;
        end
    end

    always_comb begin
        st_d = st_q;
        if (last) begin
            if (nx_bad)                   st_d = ST_REJ;
            else if (nx_dly != '0)        st_d = ST_PRE;
            else if (nx_rz && nx_wid == '0) st_d = ST_POST;
            else                          st_d = ST_ACT;
        end else begin
            unique case (st_q)
                ST_PRE:  if (tick_nxt == cu_dly)
                             st_d = (cu_rz && cu_wid == '0) ? ST_POST : ST_ACT;
                ST_ACT:  if (cu_rz && {1'b0, tick_nxt} == end_tk)
                             st_d = ST_POST;
                ST_POST: st_d = ST_POST;
                ST_REJ:  st_d = ST_REJ;
            endcase
        end
    end

    always_comb begin
        drive = hold_q;
        unique case (st_q)
            ST_PRE:  drive = cu_rz ? cu_neg : hold_q;
            ST_ACT:  drive = cu_rz ? (cu_pat ^ cu_neg) : cu_pat;
            ST_POST: drive = cu_neg;
            ST_REJ:  drive = hold_q;
        endcase
    end
endmodule

// File: rtl/fmt_strobe_cmp.sv
module fmt_strobe_cmp #(
    parameter int N  = 8,
    parameter int TW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tick,
    input  logic          last,
    input  logic [TW-1:0] cu_stb,
    input  logic          cu_exp,
    input  logic          cu_cmp,
    input  logic          cu_bad,
    input  logic          dut_resp,
    output logic          fail
);
    logic smp_q, seen, at_stb;

    assign at_stb = (tick == cu_stb);
    assign seen   = at_stb ? dut_resp : smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
            fail  <= 1'b0;
        end else begin
            if (at_stb) smp_q <= dut_resp;
            if (last)   fail  <= cu_cmp && !cu_bad && (seen != cu_exp);
        end
    end
endmodule

// File: rtl/pin_wave_formatter.sv
module pin_wave_formatter #(
    parameter int N = 8,
    localparam int TW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pat_bit,
    input  logic          exp_bit,
    input  logic          cmp_en,
    input  logic          rz_mode,
    input  logic          neg_pulse,
    input  logic [TW-1:0] delay_ticks,
    input  logic [TW-1:0] width_ticks,
    input  logic [TW-1:0] strobe_tick,
    input  logic          dut_resp,
    output logic          drive,
    output logic          period_start,
    output logic          fail,
    output logic          cfg_err
);
    localparam logic [TW:0] N_W = (TW + 1)'(N);

    logic [TW-1:0] tick, tick_nxt;
    logic          last;
    logic          new_bad;

    logic          c_rz, c_neg, c_pat, c_exp, c_cmp, c_bad;
    logic [TW-1:0] c_dly, c_wid, c_stb;

    assign new_bad = ({1'b0, delay_ticks} >= N_W) ||
                     ({1'b0, strobe_tick} >= N_W) ||
                     (rz_mode && ({1'b0, delay_ticks} + {1'b0, width_ticks} > N_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {c_rz, c_neg, c_pat, c_exp, c_cmp, c_bad} <= '0;
            c_dly <= '0;
            c_wid <= '0;
            c_stb <= '0;
        end else if (last) begin
            c_rz  <= rz_mode;
            c_neg <= neg_pulse;
            c_pat <= pat_bit;
            c_exp <= exp_bit;
            c_cmp <= cmp_en;
            c_bad <= new_bad;
            c_dly <= delay_ticks;
            c_wid <= width_ticks;
            c_stb <= strobe_tick;
        end
    end

    fmt_tick_ctr #(.N(N), .TW(TW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tick_nxt(tick_nxt), .last(last)
    );

    fmt_shaper #(.N(N), .TW(TW)) u_shp (
        .clk(clk), .rst_n(rst_n), .last(last), .tick_nxt(tick_nxt),
        .nx_rz(rz_mode), .nx_dly(delay_ticks), .nx_wid(width_ticks), .nx_bad(new_bad),
        .cu_rz(c_rz), .cu_neg(c_neg), .cu_pat(c_pat), .cu_dly(c_dly), .cu_wid(c_wid),
        .drive(drive)
    );

    fmt_strobe_cmp #(.N(N), .TW(TW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .last(last),
        .cu_stb(c_stb), .cu_exp(c_exp), .cu_cmp(c_cmp), .cu_bad(c_bad),
        .dut_resp(dut_resp), .fail(fail)
    );

    assign period_start = (tick == '0);
    assign cfg_err      = c_bad;

    // R3
    nrz_one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_rz && !c_bad && tick != c_dly) |-> $stable(drive));

    // R4, R5
    rz_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rz && !c_bad && tick < c_dly) |-> (drive == c_neg));

    // R8
    rej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_bad && tick != '0) |-> $stable(drive));

    // R9
    cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(c_cmp && !c_bad));
endmodule

// File: tb/sim_pin_wave_formatter.sv
module sim_pin_wave_formatter;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pat_bit = 0, exp_bit = 0, cmp_en = 0, rz_mode = 0, neg_pulse = 0, dut_resp = 0;
    logic [3:0] delay_ticks = 0, width_ticks = 0, strobe_tick = 0;
    logic drive, period_start, fail, cfg_err;

    int checks = 0;
    int errors = 0;
    logic lvl = 1'b0;

    always #2 clk = ~clk;

    pin_wave_formatter #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pat_bit(pat_bit), .exp_bit(exp_bit), .cmp_en(cmp_en),
        .rz_mode(rz_mode), .neg_pulse(neg_pulse), .delay_ticks(delay_ticks),
        .width_ticks(width_ticks), .strobe_tick(strobe_tick), .dut_resp(dut_resp),
        .drive(drive), .period_start(period_start), .fail(fail), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic       rz;
        logic       neg;
        logic [3:0] d;
        logic [3:0] w;
        logic [3:0] s;
        logic       pat;
        logic       expb;
        logic       cmp;
        logic       resp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 4'd3, 4'd0, 4'd2, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b0, 4'd0, 4'd0, 4'd6, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b1, 4'd7, 4'd0, 4'd7, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 4'd2, 4'd3, 4'd3, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 4'd1, 4'd4, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 4'd4, 4'd4, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 4'd1, 4'd3, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 4'd2, 4'd2, 4'd1, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 4'd2, 4'd0, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 4'd8, 4'd0, 4'd1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b0, 4'd5, 4'd4, 4'd1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b0, 4'd1, 4'd0, 4'd8, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    function automatic logic is_bad(vec_t v);
        return (int'(v.d) >= N) || (int'(v.s) >= N) || (v.rz && int'(v.d) + int'(v.w) > N);
    endfunction

    function automatic logic [7:0] exp_wave(vec_t v, logic l);
        logic [7:0] r;
        for (int t = 0; t < N; t++) begin
            if (is_bad(v))   r[t] = l;
            else if (!v.rz)  r[t] = (t < int'(v.d)) ? l : v.pat;
            else             r[t] = (v.pat && t >= int'(v.d) && t < int'(v.d) + int'(v.w)) ? ~v.neg : v.neg;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic wait_ps();
        do @(negedge clk); while (!period_start);
    endtask

    task automatic grab(output logic [7:0] w);
        for (int t = 0; t < N; t++) begin
            w[t] = drive;
            if (t < N - 1) @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired got 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] w;
        int n;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 drive", {7'd0, drive}, 8'd0);
        check("R10 fail", {7'd0, fail}, 8'd0);
        check("R10 cfg_err", {7'd0, cfg_err}, 8'd0);
        rst_n = 1'b1;

        // R1 period spacing
        wait_ps();
        n = 0;
        do begin @(negedge clk); n++; end while (!period_start);
        check("R1 period length", 8'(n), 8'(N));

        // table walk: R3 R4 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            rz_mode = v.rz; neg_pulse = v.neg; delay_ticks = v.d; width_ticks = v.w;
            strobe_tick = v.s; pat_bit = v.pat; exp_bit = v.expb; cmp_en = v.cmp;
            wait_ps();
            dut_resp = v.resp;
            check($sformatf("R8 cfg_err vec %0d", i), {7'd0, cfg_err}, {7'd0, is_bad(v)});
            grab(w);
            check($sformatf("R3/R4/R5/R6 wave vec %0d", i), w, exp_wave(v, lvl));
            if (!is_bad(v)) lvl = v.rz ? v.neg : v.pat;
            wait_ps();
            check($sformatf("R9 fail vec %0d", i), {7'd0, fail},
                  {7'd0, !is_bad(v) && v.cmp && (v.resp != v.expb)});
        end

        // R2 mid-period change deferred
        rz_mode = 0; delay_ticks = 0; pat_bit = 1; cmp_en = 0; strobe_tick = 0;
        wait_ps();
        for (int t = 0; t < N; t++) begin
            w[t] = drive;
            if (t == 2) pat_bit = 0;
            if (t < N - 1) @(negedge clk);
        end
        check("R2 no mid-period effect", w, 8'hFF);
        wait_ps();
        check("R2 change in next period", {7'd0, drive}, 8'd0);

        // R7 strobe point only
        pat_bit = 0; cmp_en = 1; exp_bit = 1; strobe_tick = 4'd5;
        wait_ps();
        wait_ps();
        for (int t = 0; t < N; t++) begin
            dut_resp = (t == 5);
            if (t < N - 1) @(negedge clk);
        end
        wait_ps();
        check("R7 match only at strobe", {7'd0, fail}, 8'd0);
        for (int t = 0; t < N; t++) begin
            dut_resp = (t != 5);
            if (t < N - 1) @(negedge clk);
        end
        wait_ps();
        check("R7 mismatch only at strobe", {7'd0, fail}, 8'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule